// File: doc/BRIEF.md
# Memory Test Sequencer with Pushbutton Control

This block exercises a burst-oriented memory controller from a board's switches, pushbuttons and LEDs. After the reset switch is released it stays silent until the controller raises its initialisation-complete flag. It then fills a block of consecutive 64-bit words with an index-derived pattern and reads back the word at address 0. One byte of that word, chosen by a 3-bit switch field, appears on eight LEDs.

Once the automatic pass is over, the block waits for manual commands. Two buttons step a word pointer up and down. A third button reads the word at the pointer and shows it. A fourth button writes a fixed 64-bit constant at the pointer. Every 64-bit word crosses the memory port as four 16-bit beats, least significant first. A separate heartbeat LED toggles at a fixed rate for as long as the block is clocked.

The memory side is a ready/valid command channel. A write command is followed by four write beats, each handed over on `wr_beat_valid && wr_beat_ready`. A read command is answered by four `rd_beat_valid` pulses, which cannot be stalled.

Top module: `memtest_sequencer`

## Requirements
- R1: No command is presented (`cmd_valid` stays 0) until `mc_init_done` has been seen high after reset.
- R2: The automatic pass issues FILL_WORDS write commands to addresses 0, 1, ..., FILL_WORDS-1 in ascending order, then exactly one read command at address 0, then goes idle.
- R3: Every write command is followed by exactly four write beats before the next command, and every read takes four read beats. Beat k carries word bits [16k+15:16k], so beat 0 is the least significant.
- R4: During the fill, beat k of word n holds the 16-bit value {2'b11, k[1:0], n[11:0]}.
- R5: `led` equals bits [8s+7:8s] of the most recently read word, where s = `byte_sel`. After reset, `led` is 0.
- R6: Asserting `rst_sw` clears the displayed word and the pointer and aborts any activity. Releasing it restarts the automatic pass.
- R7: Each accepted up or down press moves the pointer by exactly one word, wrapping modulo 2^ADDR_W. The pointer is 0 when the automatic pass ends.
- R8: An accepted read press reads the word at the pointer, and that word replaces the displayed one.
- R9: An accepted write press stores FIXED_WORD at the pointer.
- R10: `led_alive` toggles every BLINK_HALF clock cycles, whatever the sequencer is doing.
- R11: A button level shorter than DEB_CYCLES cycles has no effect. A press held for any length of time produces exactly one action.
- R12: Button actions that arrive while a read or write is in progress are discarded.
- R13: While a command or a write beat is offered but not accepted, it stays offered with unchanged address, direction and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_sw | input | 1 | Reset switch, active high, synchronous |
| btn_up | input | 1 | Raw pushbutton: pointer +1 |
| btn_down | input | 1 | Raw pushbutton: pointer -1 |
| btn_read | input | 1 | Raw pushbutton: read word at pointer |
| btn_write | input | 1 | Raw pushbutton: write fixed word at pointer |
| byte_sel | input | SEL_W (3) | Byte of the displayed word shown on `led` |
| led | output | 8 | Selected byte of the last read word |
| led_alive | output | 1 | Heartbeat LED |
| mc_init_done | input | 1 | Controller initialisation complete |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Controller accepts command |
| cmd_write | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | ADDR_W | Word address of the command |
| wr_beat_valid | output | 1 | Write beat offered |
| wr_beat_ready | input | 1 | Controller accepts write beat |
| wr_beat_data | output | 16 | Write beat data |
| rd_beat_valid | input | 1 | Read beat present |
| rd_beat_data | input | 16 | Read beat data |

## Verification
The bench goes after pointer wrap below address 0. A design that stepped the pointer in a wider register, or clamped it, would read the wrong address. A controller that stalls commands and beats on a pattern checks beat order and hold behaviour: reversed beats, or data that changes under a stall, leave a corrupted word in the memory model. Short glitches and long holds on a button catch a debouncer that fires on noise or repeats while the button is held. An up press made during a long read delay must leave the pointer unchanged, which catches a sequencer that queues actions while busy. A reset in mid-session must give a complete second fill, with the pointer back at 0.

// File: rtl/mts_pkg.sv
package mts_pkg;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_CMD,
      ST_WBEAT,
      ST_RBEAT,
      ST_IDLE
   } mts_state_e;

   typedef enum logic [1:0] {
      PH_FILL,
      PH_CHECK,
      PH_MANUAL
   } mts_phase_e;

   typedef struct packed {
      logic up;
      logic down;
      logic rd;
      logic wr;
   } mts_btn_t;

   // fill pattern: marker bits, beat index, word index
   function automatic logic [15:0] fill_beat(input logic [11:0] idx, input logic [1:0] k);
      return {2'b11, k, idx};
   endfunction

endpackage

// File: rtl/mts_debounce.sv
module mts_debounce #(
   parameter int DEB_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   output logic pulse
);
   logic [1:0] sync_q;
   logic       stable_q;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[0], raw};
   end

   generate
      if (DEB_CYCLES <= 1) begin : g_plain
         always_ff @(posedge clk) begin
            if (rst) begin
               stable_q <= 1'b0;
               pulse    <= 1'b0;
            end else begin
               stable_q <= sync_q[1];
               pulse    <= sync_q[1] & ~stable_q;
            end
         end
      end else begin : g_filter
         localparam int CNT_W = $clog2(DEB_CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;
         logic             settle;
         assign settle = (cnt_q == CNT_W'(DEB_CYCLES - 1));

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q    <= '0;
               stable_q <= 1'b0;
               pulse    <= 1'b0;
            end else begin
               pulse <= 1'b0;
               if (sync_q[1] != stable_q) begin
                  if (settle) begin
                     cnt_q    <= '0;
                     stable_q <= sync_q[1];
                     pulse    <= sync_q[1];
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end else begin
                  cnt_q <= '0;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mts_heartbeat.sv
module mts_heartbeat #(
   parameter int BLINK_HALF = 25000000
) (
   input  logic clk,
   input  logic rst,
   output logic led
);
   localparam int CNT_W = $clog2(BLINK_HALF + 1);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         led   <= 1'b0;
      end else if (cnt_q == CNT_W'(BLINK_HALF - 1)) begin
         cnt_q <= '0;
         led   <= ~led;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/mts_engine.sv
module mts_engine
   import mts_pkg::*;
#(
   parameter int          ADDR_W     = 10,
   parameter int          FILL_WORDS = 16,
   parameter int          BEAT_W     = 16,
   parameter int          BEATS      = 4,
   parameter logic [63:0] FIXED_WORD = 64'hFEED_0BAD_CAFE_1234
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    init_done,
   input  mts_btn_t                act,
   output logic                    cmd_valid,
   input  logic                    cmd_ready,
   output logic                    cmd_write,
   output logic [ADDR_W-1:0]       cmd_addr,
   output logic                    wr_beat_valid,
   input  logic                    wr_beat_ready,
   output logic [BEAT_W-1:0]       wr_beat_data,
   input  logic                    rd_beat_valid,
   input  logic [BEAT_W-1:0]       rd_beat_data,
   output logic [BEAT_W*BEATS-1:0] shown_word
);
   localparam int WORD_W  = BEAT_W * BEATS;
   localparam int BEAT_IW = $clog2(BEATS);
   localparam int IDX_W   = $clog2(FILL_WORDS);

   mts_state_e          state_q;
   mts_phase_e          phase_q;
   logic                op_wr_q;
   logic [ADDR_W-1:0]   op_addr_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic [IDX_W-1:0]    idx_q;
   logic [BEAT_IW-1:0]  beat_q;
   logic [WORD_W-1:0]   rd_buf_q;
   logic [WORD_W-1:0]   buf_next;
   logic [WORD_W-1:0]   fill_w;
   logic [WORD_W-1:0]   out_word;
   logic                last_beat;
   logic                op_done;

   always_comb begin
      fill_w = '0;
      for (int k = 0; k < BEATS; k++) begin
         fill_w[k*BEAT_W +: BEAT_W] = BEAT_W'(fill_beat(12'(idx_q), 2'(k)));
      end
   end

   assign out_word  = (phase_q == PH_FILL) ? fill_w : WORD_W'(FIXED_WORD);
   assign last_beat = (beat_q == BEAT_IW'(BEATS - 1));

   always_comb begin
      buf_next = rd_buf_q;
      buf_next[beat_q*BEAT_W +: BEAT_W] = rd_beat_data;
   end

   assign op_done = last_beat &&
                    (((state_q == ST_WBEAT) && wr_beat_ready) ||
                     ((state_q == ST_RBEAT) && rd_beat_valid));

   assign cmd_valid     = (state_q == ST_CMD);
   assign cmd_write     = op_wr_q;
   assign cmd_addr      = op_addr_q;
   assign wr_beat_valid = (state_q == ST_WBEAT);
   assign wr_beat_data  = out_word[beat_q*BEAT_W +: BEAT_W];
   assign shown_word    = rd_buf_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_INIT;
         phase_q   <= PH_FILL;
         op_wr_q   <= 1'b1;
         op_addr_q <= '0;
         ptr_q     <= '0;
         idx_q     <= '0;
         beat_q    <= '0;
         rd_buf_q  <= '0;
      end else begin
         case (state_q)
            ST_INIT: begin
               if (init_done) begin
                  state_q   <= ST_CMD;
                  phase_q   <= PH_FILL;
                  op_wr_q   <= 1'b1;
                  op_addr_q <= '0;
                  idx_q     <= '0;
               end
            end
            ST_CMD: begin
               if (cmd_ready) begin
                  beat_q  <= '0;
                  state_q <= op_wr_q ? ST_WBEAT : ST_RBEAT;
               end
            end
            ST_WBEAT: begin
               if (wr_beat_ready) beat_q <= beat_q + BEAT_IW'(1);
            end
            ST_RBEAT: begin
               if (rd_beat_valid) begin
                  beat_q <= beat_q + BEAT_IW'(1);
                  if (!last_beat) rd_buf_q <= buf_next;
               end
            end
            ST_IDLE: begin
               if (act.rd) begin
                  op_addr_q <= ptr_q;
                  op_wr_q   <= 1'b0;
                  state_q   <= ST_CMD;
               end else if (act.wr) begin
                  op_addr_q <= ptr_q;
                  op_wr_q   <= 1'b1;
                  state_q   <= ST_CMD;
               end else if (act.up) begin
                  ptr_q <= ptr_q + ADDR_W'(1);
               end else if (act.down) begin
                  ptr_q <= ptr_q - ADDR_W'(1);
               end
            end
            default: state_q <= ST_INIT;
         endcase

         if (op_done) begin
            if (state_q == ST_RBEAT) rd_buf_q <= buf_next;
            case (phase_q)
               PH_FILL: begin
                  state_q <= ST_CMD;
                  if (idx_q == IDX_W'(FILL_WORDS - 1)) begin
                     phase_q   <= PH_CHECK;
                     op_wr_q   <= 1'b0;
                     op_addr_q <= '0;
                  end else begin
                     idx_q     <= idx_q + IDX_W'(1);
                     op_addr_q <= op_addr_q + ADDR_W'(1);
                  end
               end
               PH_CHECK: begin
                  phase_q <= PH_MANUAL;
                  state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/memtest_sequencer.sv
module memtest_sequencer
   import mts_pkg::*;
#(
   parameter int          ADDR_W     = 10,
   parameter int          FILL_WORDS = 16,
   parameter int          BEAT_W     = 16,
   parameter int          BEATS      = 4,
   parameter int          DEB_CYCLES = 50000,
   parameter int          BLINK_HALF = 25000000,
   parameter logic [63:0] FIXED_WORD = 64'hFEED_0BAD_CAFE_1234,
   localparam int         WORD_W     = BEAT_W * BEATS,
   localparam int         SEL_W      = $clog2(WORD_W / 8)
) (
   input  logic              clk,
   input  logic              rst_sw,
   input  logic              btn_up,
   input  logic              btn_down,
   input  logic              btn_read,
   input  logic              btn_write,
   input  logic [SEL_W-1:0]  byte_sel,
   output logic [7:0]        led,
   output logic              led_alive,
   input  logic              mc_init_done,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic              cmd_write,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              wr_beat_valid,
   input  logic              wr_beat_ready,
   output logic [BEAT_W-1:0] wr_beat_data,
   input  logic              rd_beat_valid,
   input  logic [BEAT_W-1:0] rd_beat_data
);
   localparam int NBTN = 4;

   if (BEATS < 2 || BEATS > 4) begin : g_chk_beats
      $error("BEATS must be 2..4");
   end
   if (BEAT_W < 16) begin : g_chk_beat_w
      $error("BEAT_W must be at least 16");
   end
   if (FILL_WORDS < 2 || FILL_WORDS > 4096 || FILL_WORDS > (1 << ADDR_W)) begin : g_chk_fill
      $error("FILL_WORDS must be 2..4096 and fit the address range");
   end
   if (WORD_W > 64) begin : g_chk_word
      $error("word must fit FIXED_WORD");
   end

   logic [NBTN-1:0]   raw_btn;
   logic [NBTN-1:0]   act_vec;
   mts_btn_t          act;
   logic [WORD_W-1:0] shown_word;

   assign raw_btn = {btn_up, btn_down, btn_read, btn_write};

   for (genvar g = 0; g < NBTN; g++) begin : g_btn
      mts_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_db (
         .clk   (clk),
         .rst   (rst_sw),
         .raw   (raw_btn[g]),
         .pulse (act_vec[g])
      );
   end

   assign act = mts_btn_t'(act_vec);

   mts_engine #(
      .ADDR_W     (ADDR_W),
      .FILL_WORDS (FILL_WORDS),
      .BEAT_W     (BEAT_W),
      .BEATS      (BEATS),
      .FIXED_WORD (FIXED_WORD)
   ) u_engine (
      .clk           (clk),
      .rst           (rst_sw),
      .init_done     (mc_init_done),
      .act           (act),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_write     (cmd_write),
      .cmd_addr      (cmd_addr),
      .wr_beat_valid (wr_beat_valid),
      .wr_beat_ready (wr_beat_ready),
      .wr_beat_data  (wr_beat_data),
      .rd_beat_valid (rd_beat_valid),
      .rd_beat_data  (rd_beat_data),
      .shown_word    (shown_word)
   );

   assign led = shown_word[byte_sel*8 +: 8];

   mts_heartbeat #(.BLINK_HALF(BLINK_HALF)) u_hb (
      .clk (clk),
      .rst (rst_sw),
      .led (led_alive)
   );
endmodule

// File: rtl/mts_checker.sv
module mts_checker #(
   parameter int ADDR_W     = 10,
   parameter int BEAT_W     = 16,
   parameter int BEATS      = 4,
   parameter int BLINK_HALF = 25000000
) (
   input logic              clk,
   input logic              rst_sw,
   input logic              mc_init_done,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              cmd_write,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              wr_beat_valid,
   input logic              wr_beat_ready,
   input logic [BEAT_W-1:0] wr_beat_data,
   input logic              led_alive
);
   logic        seen_init;
   logic [3:0]  wr_left;
   logic        alive_prev;
   logic [31:0] alive_run;

   always_ff @(posedge clk) begin
      if (rst_sw) begin
         seen_init  <= 1'b0;
         wr_left    <= '0;
         alive_prev <= 1'b0;
         alive_run  <= '0;
      end else begin
         seen_init <= seen_init | mc_init_done;
         if (cmd_valid && cmd_ready && cmd_write) wr_left <= 4'(BEATS);
         else if (wr_beat_valid && wr_beat_ready) wr_left <= wr_left - 4'd1;
         alive_prev <= led_alive;
         alive_run  <= (led_alive != alive_prev) ? 32'd1 : alive_run + 32'd1;
      end
   end

   AST_NO_EARLY_CMD: assert property (@(posedge clk) disable iff (rst_sw)
      !seen_init |-> !cmd_valid);                                             // R1
   AST_BEAT_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst_sw)
      wr_beat_valid |-> (wr_left != 4'd0));                                   // R3
   AST_NO_CMD_MID_BURST: assert property (@(posedge clk) disable iff (rst_sw)
      cmd_valid |-> (wr_left == 4'd0));                                       // R3
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst_sw)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_write))); // R13
   AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst_sw)
      (wr_beat_valid && !wr_beat_ready) |=> (wr_beat_valid && $stable(wr_beat_data))); // R13
   AST_BLINK_PERIOD: assert property (@(posedge clk) disable iff (rst_sw)
      alive_run <= 32'(BLINK_HALF));                                          // R10
endmodule

bind memtest_sequencer mts_checker #(
   .ADDR_W     (ADDR_W),
   .BEAT_W     (BEAT_W),
   .BEATS      (BEATS),
   .BLINK_HALF (BLINK_HALF)
) u_chk (
   .clk           (clk),
   .rst_sw        (rst_sw),
   .mc_init_done  (mc_init_done),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .cmd_write     (cmd_write),
   .cmd_addr      (cmd_addr),
   .wr_beat_valid (wr_beat_valid),
   .wr_beat_ready (wr_beat_ready),
   .wr_beat_data  (wr_beat_data),
   .led_alive     (led_alive)
);

// File: tb/memtest_sequencer_bench.sv
module memtest_sequencer_bench;
   localparam int          AW    = 4;
   localparam int          FW    = 16;
   localparam int          DEB   = 4;
   localparam int          BH    = 10;
   localparam logic [63:0] FIXED = 64'hD00D_F00D_1357_2468;

   logic        clk = 1'b0;
   logic        rst_sw = 1'b1;
   logic        btn_up = 1'b0, btn_down = 1'b0, btn_read = 1'b0, btn_write = 1'b0;
   logic [2:0]  byte_sel = '0;
   logic [7:0]  led;
   logic        led_alive;
   logic        mc_init_done = 1'b0;
   logic        cmd_valid, cmd_write;
   logic        cmd_ready = 1'b0;
   logic [AW-1:0] cmd_addr;
   logic        wr_beat_valid;
   logic        wr_beat_ready = 1'b0;
   logic [15:0] wr_beat_data;
   logic        rd_beat_valid = 1'b0;
   logic [15:0] rd_beat_data = '0;

   int n_chk = 0;
   int n_fail = 0;

   memtest_sequencer #(
      .ADDR_W(AW), .FILL_WORDS(FW), .BEAT_W(16), .BEATS(4),
      .DEB_CYCLES(DEB), .BLINK_HALF(BH), .FIXED_WORD(FIXED)
   ) u_memtest_sequencer (
      .clk(clk), .rst_sw(rst_sw),
      .btn_up(btn_up), .btn_down(btn_down), .btn_read(btn_read), .btn_write(btn_write),
      .byte_sel(byte_sel), .led(led), .led_alive(led_alive),
      .mc_init_done(mc_init_done),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
      .wr_beat_valid(wr_beat_valid), .wr_beat_ready(wr_beat_ready), .wr_beat_data(wr_beat_data),
      .rd_beat_valid(rd_beat_valid), .rd_beat_data(rd_beat_data)
   );

   always #5 clk = ~clk;

   // ---------------- memory model ----------------
   logic [63:0]   mem [16];
   int            n_wcmd = 0, n_rcmd = 0, n_wbeat = 0, n_rdone = 0;
   logic [AW-1:0] last_addr = '0;
   bit            early_cmd = 0, order_bad = 0;
   int            rd_delay_set = 3;
   logic [AW-1:0] w_addr = '0, r_addr = '0;
   int            wbeat = 0, rbeat = 0, rdly = 0, cyc = 0;
   bit            r_pend = 0;

   initial for (int i = 0; i < 16; i++) mem[i] = '0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_sw) begin
         if (cmd_valid && cmd_ready) begin
            last_addr = cmd_addr;
            if (!mc_init_done) early_cmd = 1;
            if (cmd_write) begin
               if (n_wcmd < FW && cmd_addr != AW'(n_wcmd)) order_bad = 1;
               n_wcmd++;
               w_addr = cmd_addr;
               wbeat  = 0;
            end else begin
               n_rcmd++;
               r_addr = cmd_addr;
               r_pend = 1;
               rbeat  = 0;
               rdly   = rd_delay_set;
            end
         end
         if (wr_beat_valid && wr_beat_ready) begin
            mem[w_addr][wbeat*16 +: 16] = wr_beat_data;
            wbeat++;
            n_wbeat++;
         end
         if (rd_beat_valid) begin
            rbeat++;
            if (rbeat == 4) begin
               r_pend = 0;
               n_rdone++;
            end
         end
      end
   end

   always @(negedge clk) begin
      cmd_ready     = (cyc % 3) != 0;
      wr_beat_ready = (cyc % 4) != 1;
      if (r_pend && rdly > 0) rdly--;
      if (r_pend && rdly == 0 && rbeat < 4 && (cyc % 2) == 0) begin
         rd_beat_valid = 1'b1;
         rd_beat_data  = mem[r_addr][rbeat*16 +: 16];
      end else begin
         rd_beat_valid = 1'b0;
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [63:0] fword(input int n);
      logic [63:0] w;
      for (int k = 0; k < 4; k++) w[k*16 +: 16] = {2'b11, 2'(k), 12'(n)};
      return w;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_btn(input int which, input logic v);
      case (which)
         0: btn_up = v;
         1: btn_down = v;
         2: btn_read = v;
         default: btn_write = v;
      endcase
   endtask

   task automatic press(input int which, input int hold);
      set_btn(which, 1'b1);
      cycles(hold);
      set_btn(which, 1'b0);
      cycles(20);
   endtask

   task automatic wait_rdone(input int target, input string req);
      int t = 0;
      while (n_rdone < target && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk({req, " read completes"}, 64'(n_rdone >= target), 64'd1);
      cycles(3);
   endtask

   task automatic do_read(input string req);
      int tgt = n_rdone + 1;
      press(2, 20);
      wait_rdone(tgt, req);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      rst_sw = 1'b1;
      cycles(5);
      rst_sw = 1'b0;
      cycles(40);
      chk("R1 no command before init", 64'(cmd_valid), 64'd0);
      chk("R1 no write command count", 64'(n_wcmd), 64'd0);
      chk("R5 led zero after reset", 64'(led), 64'd0);
      chk("R3 no beat before command", 64'(wr_beat_valid), 64'd0);
   endtask

   task automatic t_auto;
      mc_init_done = 1'b1;
      wait_rdone(1, "R2");
      chk("R2 write command count", 64'(n_wcmd), 64'(FW));
      chk("R2 single readback", 64'(n_rcmd), 64'd1);
      chk("R2 readback address 0", 64'(last_addr), 64'd0);
      chk("R2 ascending fill addresses", 64'(order_bad), 64'd0);
      chk("R1 no early command", 64'(early_cmd), 64'd0);
      for (int n = 0; n < FW; n++) chk("R4 R3 fill word content", mem[n], fword(n));
      for (int s = 0; s < 8; s++) begin
         byte_sel = 3'(s);
         #1;
         chk("R5 byte select", 64'(led), 64'(fword(0)[s*8 +: 8]));
      end
   endtask

   task automatic t_blink;
      logic start;
      int   len = 0;
      start = led_alive;
      while (led_alive == start) @(negedge clk);
      start = led_alive;
      while (led_alive == start && len < 100) begin
         @(negedge clk);
         len++;
      end
      chk("R10 heartbeat half period", 64'(len), 64'(BH));
   endtask

   task automatic t_pointer;
      press(1, 20);
      do_read("R7");
      chk("R7 pointer wraps below zero", 64'(last_addr), 64'(FW - 1));
      byte_sel = 3'd7;
      #1;
      chk("R8 read replaces shown word", 64'(led), 64'(fword(FW - 1)[63:56]));
      press(0, 20);
      press(0, 20);
      do_read("R7");
      chk("R7 pointer wraps above top", 64'(last_addr), 64'd1);
      #1;
      chk("R8 shown word at pointer 1", 64'(led), 64'(fword(1)[63:56]));
   endtask

   task automatic t_write;
      int tgt;
      press(0, 20);
      tgt = n_wbeat + 4;
      press(3, 20);
      for (int t = 0; t < 2000 && n_wbeat < tgt; t++) @(negedge clk);
      cycles(3);
      chk("R9 fixed word stored", mem[2], FIXED);
      chk("R9 write address is pointer", 64'(last_addr), 64'd2);
      do_read("R8");
      byte_sel = 3'd0;
      #1;
      chk("R8 fixed word shown", 64'(led), 64'(FIXED[7:0]));
   endtask

   task automatic t_bounce;
      btn_up = 1'b1;
      cycles(2);
      btn_up = 1'b0;
      cycles(30);
      do_read("R11");
      chk("R11 glitch ignored", 64'(last_addr), 64'd2);
      press(0, 80);
      do_read("R11");
      chk("R11 long hold one step", 64'(last_addr), 64'd3);
   endtask

   task automatic t_busy;
      int tgt = n_rdone + 1;
      rd_delay_set = 80;
      press(2, 20);
      press(0, 20);
      wait_rdone(tgt, "R12");
      rd_delay_set = 3;
      do_read("R12");
      chk("R12 press while busy dropped", 64'(last_addr), 64'd3);
   endtask

   task automatic t_restart;
      rst_sw = 1'b1;
      cycles(3);
      chk("R6 led cleared by reset", 64'(led), 64'd0);
      chk("R6 no command in reset", 64'(cmd_valid), 64'd0);
      n_wcmd = 0;
      n_rcmd = 0;
      n_rdone = 0;
      order_bad = 0;
      rst_sw = 1'b0;
      wait_rdone(1, "R6");
      chk("R6 fill repeated", 64'(n_wcmd), 64'(FW));
      chk("R6 fixed word overwritten", mem[2], fword(2));
      chk("R6 ascending refill", 64'(order_bad), 64'd0);
      do_read("R6");
      chk("R6 R7 pointer back to zero", 64'(last_addr), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_auto();
      t_blink();
      t_pointer();
      t_write();
      t_bounce();
      t_busy();
      t_restart();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule